// File: doc/BRIEF.md
# Power-Down and Startup Sequencer

This block governs when a mixed-signal device is held in power-down and how it restarts. Two requests can hold the device down. The first is an asynchronous, active-low hardware pin. The second is a software control bit that arrives as a plain level from the register logic. Both requests are resynchronized to a free-running reference clock. A low pulse on the pin counts as a power-down only if it lasts a minimum number of reference cycles, so glitches are ignored. If the software bit goes high and then low again, the block performs the same internal reset that a hardware power-down performs.

While any request is active, the block holds the oscillator enable low and keeps the internal reset asserted. When both requests clear, the oscillator enable rises and two separate timers start. The first timer sets the oscillator settling time. At its end, the gated internal clock enable turns on and the internal reset drops in that same cycle. The second timer is longer. At its end, the READY status rises, which marks entry into initialization mode. A new request at any point in this sequence clears the clock enable and READY on the next edge, and the sequence starts again from the beginning.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While `rst_ref_n` is low, and after it is released with the pin still low, the outputs are `pd_active`=1, `osc_en`=0, `clk_en`=0, `int_rst`=1 and `ready`=0.
- R2: Suppose `pd_pin_n` falls just after edge 0 and stays low for at least `QUAL_CYC` reference cycles. Then `pd_active` rises after edge `QUAL_CYC`+2 and not before that edge.
- R3: A low pulse on `pd_pin_n` that lasts `QUAL_CYC`-1 cycles changes no output.
- R4: When `sw_pd` is 1, the device is in power-down, and `pd_active` rises after the 3rd edge following the rise of `sw_pd`. Power-down ends only when the pin is 1 and `sw_pd` is 0. A qualified low on the pin holds power-down after `sw_pd` returns to 0.
- R5: A 0→1→0 sequence on `sw_pd` issues one extra cycle of internal reset. As a result, `osc_en` rises after the 4th edge following the fall of `sw_pd`. A pin release gives the 3rd edge instead.
- R6: `osc_en` is 0 during every power-down. `osc_en` rises after the 3rd edge following the rise of `pd_pin_n` when `sw_pd` is 0, and `pd_active` is always its complement.
- R7: `clk_en` rises exactly `SETTLE_CYC` edges after `osc_en` rises. `int_rst` falls on the same edge, and `int_rst` is the complement of `clk_en` at all times.
- R8: `ready` rises exactly `READY_CYC` edges after `osc_en` rises. `READY_CYC` must be greater than `SETTLE_CYC`.
- R9: A request that arrives while the settle timer or the READY timer is running clears `clk_en` and `ready` on the edge where `pd_active` rises. The full timed sequence then runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_ref_n | input | 1 | Asynchronous active-low power-on reset |
| pd_pin_n | input | 1 | Asynchronous hardware power-down request, active low |
| sw_pd | input | 1 | Software power-down bit, 1 requests power-down |
| pd_active | output | 1 | Device is in power-down |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | Gated internal clock enable |
| int_rst | output | 1 | Internal reset, active high |
| ready | output | 1 | Initialization-mode status |

## Verification
Every input change adds two synchronizer edges and one sequencer edge before any output moves. The bench therefore counts edges from the negative edge at which it drives an input. It predicts `osc_en` at edge d, where d is 3 for a pin release and 4 for a software release. It predicts `clk_en` at d+`SETTLE_CYC` and `ready` at d+`READY_CYC`. A pin power-down is predicted at `QUAL_CYC`+2 and a software power-down at 3. The bench compares all five outputs on every negative edge across each of these windows, so a result one cycle early or late counts as a miscompare.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
   typedef enum logic [1:0] {
      ST_OFF    = 2'd0,
      ST_SETTLE = 2'd1,
      ST_RUN    = 2'd2,
      ST_READY  = 2'd3
   } pwr_state_e;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
   parameter int             W       = 2,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pwrseq_lowqual.sv
module pwrseq_lowqual #(
   parameter int QUAL_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_n,
   output logic pd_hit
);
   localparam int          QW  = (QUAL_CYC > 2) ? $clog2(QUAL_CYC) : 1;
   localparam logic [QW-1:0] SAT = QW'(QUAL_CYC - 1);

   logic [QW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              low_cnt <= SAT;
      else if (lvl_n)          low_cnt <= '0;
      else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
   end

   assign pd_hit = !lvl_n && (low_cnt == SAT);
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic hit
);
   localparam int            TW  = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [TW-1:0] END = TW'(LIMIT - 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (en && cnt != END)  cnt <= cnt + 1'b1;
   end

   assign hit = (cnt == END);
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
   import pwrseq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_CYC    = 5,
   parameter int SETTLE_CYC  = 65536,
   parameter int READY_CYC   = 4096000
) (
   input  logic clk_ref,
   input  logic rst_ref_n,
   input  logic pd_pin_n,
   input  logic sw_pd,
   output logic pd_active,
   output logic osc_en,
   output logic clk_en,
   output logic int_rst,
   output logic ready
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (QUAL_CYC < 2) begin : g_bad_qual
         $error("QUAL_CYC must be at least 2");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (READY_CYC <= SETTLE_CYC) begin : g_bad_ready
         $error("READY_CYC must exceed SETTLE_CYC");
      end
   endgenerate

   logic [1:0] req_s;
   logic       pin_s, sw_s, sw_prev;
   logic       pin_pd, sw_fall, pd_req;
   logic       settle_hit, ready_hit;
   pwr_state_e state_q;

   pwrseq_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
      .clk   (clk_ref),
      .rst_n (rst_ref_n),
      .d     ({pd_pin_n, sw_pd}),
      .q     (req_s)
   );
   assign pin_s = req_s[1];
   assign sw_s  = req_s[0];

   pwrseq_lowqual #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk    (clk_ref),
      .rst_n  (rst_ref_n),
      .lvl_n  (pin_s),
      .pd_hit (pin_pd)
   );

   always_ff @(posedge clk_ref or negedge rst_ref_n) begin
      if (!rst_ref_n) sw_prev <= 1'b0;
      else            sw_prev <= sw_s;
   end

   // falling edge of the software bit: tail of a 0-1-0 reset sequence
   assign sw_fall = sw_prev && !sw_s;
   assign pd_req  = pin_pd || sw_s || sw_fall;

   pwrseq_timer #(.LIMIT(SETTLE_CYC)) u_settle (
      .clk   (clk_ref),
      .rst_n (rst_ref_n),
      .clr   (state_q == ST_OFF),
      .en    (state_q == ST_SETTLE),
      .hit   (settle_hit)
   );

   pwrseq_timer #(.LIMIT(READY_CYC)) u_ready (
      .clk   (clk_ref),
      .rst_n (rst_ref_n),
      .clr   (state_q == ST_OFF),
      .en    (state_q == ST_SETTLE || state_q == ST_RUN),
      .hit   (ready_hit)
   );

   always_ff @(posedge clk_ref or negedge rst_ref_n) begin
      if (!rst_ref_n) begin
         state_q <= ST_OFF;
      end else if (pd_req) begin
         state_q <= ST_OFF;
      end else begin
         unique case (state_q)
            ST_OFF:    state_q <= ST_SETTLE;
            ST_SETTLE: if (settle_hit) state_q <= ST_RUN;
            ST_RUN:    if (ready_hit)  state_q <= ST_READY;
            default:   state_q <= ST_READY;
         endcase
      end
   end

   assign pd_active = (state_q == ST_OFF);
   assign osc_en    = !pd_active;
   assign clk_en    = (state_q == ST_RUN) || (state_q == ST_READY);
   assign int_rst   = !clk_en;
   assign ready     = (state_q == ST_READY);
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic pd_active,
   input logic osc_en,
   input logic clk_en,
   input logic int_rst,
   input logic ready
);
   p_pd_stops_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pd_active |-> (!osc_en && !clk_en && int_rst));

   p_clk_after_osc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en) |-> $past(osc_en));

   p_rst_drop_with_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_rst) |-> $rose(clk_en));

   p_ready_after_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(clk_en) && clk_en));

   p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_active) |-> (!ready && !clk_en));
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk u_chk (
   .clk       (clk_ref),
   .rst_n     (rst_ref_n),
   .pd_active (pd_active),
   .osc_en    (osc_en),
   .clk_en    (clk_en),
   .int_rst   (int_rst),
   .ready     (ready)
);

// File: tb/pwrseq_ctrl_tb_top.sv
module pwrseq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int Q  = 4;
   localparam int S  = 16;
   localparam int RD = 40;
   localparam int WATCHDOG = 20000;

   // output vector order: {pd_active, osc_en, clk_en, int_rst, ready}
   localparam logic [4:0] V_OFF    = 5'b10010;
   localparam logic [4:0] V_SETTLE = 5'b01010;
   localparam logic [4:0] V_RUN    = 5'b01100;
   localparam logic [4:0] V_READY  = 5'b01101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pd_n = 1'b0;
   logic swb = 1'b0;
   logic pd_active, osc_en, clk_en, int_rst, ready;
   logic [4:0] obs;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwrseq_ctrl #(.SYNC_STAGES(2), .QUAL_CYC(Q), .SETTLE_CYC(S), .READY_CYC(RD)) dut_i (
      .clk_ref   (clk),
      .rst_ref_n (rst_n),
      .pd_pin_n  (pd_n),
      .sw_pd     (swb),
      .pd_active (pd_active),
      .osc_en    (osc_en),
      .clk_en    (clk_en),
      .int_rst   (int_rst),
      .ready     (ready)
   );

   assign obs = {pd_active, osc_en, clk_en, int_rst, ready};

   function automatic logic [4:0] seq_vec(int k, int d);
      logic o, c, r;
      o = (k >= d);
      c = (k >= d + S);
      r = (k >= d + RD);
      return {!o, o, c, !c, r};
   endfunction

   task automatic chk(string req, logic [4:0] exp);
      n_vec++;
      if (obs !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: {pd,osc,clk,rst,rdy} got %b expected %b",
                  req, $time, obs, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_seq(string req, int d, int kmax);
      for (int k = 1; k <= kmax; k++) begin
         step();
         chk(req, seq_vec(k, d));
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 during reset", V_OFF);
      rst_n = 1'b1;
      step(); chk("R1 after reset", V_OFF);
      step(); chk("R1 pin still low", V_OFF);

      // pin release: R6 R7 R8 timing
      pd_n = 1'b1;
      run_seq("R6 R7 R8 pin release", 3, 3 + RD + 2);

      // R3: low pulse one cycle short of qualification
      pd_n = 1'b0;
      for (int k = 1; k <= Q + 8; k++) begin
         step();
         chk("R3 short pulse ignored", V_READY);
         if (k == Q - 1) pd_n = 1'b1;
      end

      // R2: pulse of exactly Q cycles qualifies, then R9 restart
      pd_n = 1'b0;
      for (int k = 1; k <= Q; k++) begin
         step();
         chk("R2 qualifying", V_READY);
      end
      pd_n = 1'b1;
      step(); chk("R2 not yet down", V_READY);
      run_seq("R2 R9 restart after min pulse", 2, 2 + RD + 2);

      // R2: long low enters power-down on edge Q+2
      pd_n = 1'b0;
      for (int k = 1; k <= Q + 1; k++) begin
         step();
         chk("R2 before edge Q+2", V_READY);
      end
      step(); chk("R2 down at edge Q+2", V_OFF);
      repeat (4) begin step(); chk("R2 held down", V_OFF); end
      pd_n = 1'b1;
      run_seq("R6 R7 R8 second release", 3, 3 + RD + 2);

      // R4: software bit forces power-down on edge 3
      swb = 1'b1;
      step(); chk("R4 edge 1", V_READY);
      step(); chk("R4 edge 2", V_READY);
      step(); chk("R4 down at edge 3", V_OFF);
      repeat (3) begin step(); chk("R4 held", V_OFF); end
      pd_n = 1'b0;
      repeat (Q + 4) begin step(); chk("R4 both requests", V_OFF); end
      swb = 1'b0;
      repeat (6) begin step(); chk("R4 pin still holds", V_OFF); end
      pd_n = 1'b1;
      run_seq("R4 R6 release by pin", 3, 3 + RD + 2);

      // R5: 0-1-0 on software bit adds one reset cycle
      swb = 1'b1;
      repeat (3) step();
      chk("R5 down", V_OFF);
      repeat (2) step();
      swb = 1'b0;
      run_seq("R5 software reset release", 4, 4 + RD + 2);

      // R9: request during settle phase
      swb = 1'b1;
      repeat (3) step();
      swb = 1'b0;
      run_seq("R9 into settle", 4, 10);
      swb = 1'b1;
      step(); chk("R9 settle edge 1", V_SETTLE);
      step(); chk("R9 settle edge 2", V_SETTLE);
      step(); chk("R9 settle cleared", V_OFF);
      swb = 1'b0;
      run_seq("R9 R7 rerun after settle abort", 4, 4 + S + 3);

      // R9: pin request during run phase (clock on, ready not yet)
      pd_n = 1'b0;
      for (int k = 1; k <= Q + 1; k++) begin
         step();
         chk("R9 run phase before qual", V_RUN);
      end
      step(); chk("R9 run cleared", V_OFF);
      pd_n = 1'b1;
      run_seq("R9 R8 rerun after run abort", 3, 3 + RD + 2);

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run hung, got no finish expected finish within %0d cycles",
                  WATCHDOG);
         summary();
         $finish;
      end
   end
endmodule